// File: doc/BRIEF.md
# Data Flash Access Controller

This block guards a byte-organised data storage area built as a synchronous register array. It sits between a CPU bus, a code-area rewrite indicator and a rewrite sequencer. The CPU may only read single bytes from the area. Each read takes a fixed three-cycle access that includes one wait cycle. Instruction fetches, CPU writes and reads made under a blocking condition all end in an access error. A sequencer port issues two kinds of command: byte program, which can only clear bits, and erase of one aligned 1 KB block back to 0xFF.

The area is unusable after reset until software sets an enable bit. While a program or erase runs, the block reports busy. In that time it ignores control writes, refuses low-power entry and rejects further commands. While the code area is being rewritten, every CPU access and every command is refused. Instruction fetch from the code area is outside this block and carries on during a data rewrite.

Top module: `dflash_ctrl`

## Requirements
- R1: After reset ctrlEnable is 0, busy is 0 and every byte of the array reads as 0xFF once the area is enabled.
- R2: A read accepted in cycle 0 returns cpuDone=1, cpuErr=0 and the addressed byte on cpuRdata in cycle 2, with cpuDone=0 in cycle 1. The request is sampled when cpuReq=1 and cpuFetch=0.
- R3: A request with cpuFetch=1 returns cpuDone=1, cpuErr=1 and cpuRdata=0 in cycle 1.
- R4: A request with cpuWrite=1 is refused in the same way as R3 and does not change the array.
- R5: A read while ctrlEnable=0 is refused as in R3.
- R6: While codeRewriting=1, every CPU request is refused as in R3 and every sequencer command is rejected: seqErr=1 in the next cycle and no busy.
- R7: While busy=1, a pulse on ctrlWe leaves ctrlEnable unchanged.
- R8: A cycle of lpReq gives lpGrant=1 in the next cycle when busy=0 and lpDeny=1 when busy=1. The two never assert together.
- R9: An accepted program command (seqCmdErase=0) keeps busy high for exactly PROG_CYCLES cycles. It then leaves the addressed byte equal to its old value ANDed with seqData and pulses seqDone in the cycle busy falls.
- R10: An accepted erase command (seqCmdErase=1) keeps busy high for exactly ERASE_CYCLES cycles. It then sets all bytes of the aligned BLOCK_BYTES block holding seqAddr to 0xFF and leaves other blocks untouched.
- R11: A command arriving while busy=1 is rejected with seqErr=1 in the next cycle and does not alter the array or the running operation.
- R12: A CPU read while busy=1 is refused as in R3.
- R13: A command while ctrlEnable=0 is rejected with seqErr=1 and starts no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cpuReq | input | 1 | CPU access request, one cycle |
| cpuFetch | input | 1 | Request is an instruction fetch |
| cpuWrite | input | 1 | Request is a write |
| cpuAddr | input | ADDR_W | Byte address in the data area |
| cpuRdata | output | 8 | Read data, valid with cpuDone and no error |
| cpuDone | output | 1 | Access completes this cycle |
| cpuErr | output | 1 | Access refused |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 1 | New value of the enable bit |
| ctrlEnable | output | 1 | Current enable bit |
| codeRewriting | input | 1 | Code area rewrite in progress |
| lpReq | input | 1 | Request to enter halt or stop |
| lpGrant | output | 1 | Low-power entry allowed |
| lpDeny | output | 1 | Low-power entry refused |
| seqCmdValid | input | 1 | Sequencer command strobe |
| seqCmdErase | input | 1 | 1 = block erase, 0 = byte program |
| seqAddr | input | ADDR_W | Command byte address |
| seqData | input | 8 | Program data |
| busy | output | 1 | Program or erase running |
| seqDone | output | 1 | Operation completed, one cycle |
| seqErr | output | 1 | Command rejected, one cycle |

## Verification
The hardest situation to reach is a rewrite that is still in flight while other traffic arrives: a CPU read, a control write, a low-power request and a second command. The bench starts an erase, which gives the longest busy window. It then fires each of those requests on successive cycles before busy falls. Afterwards it reads back both the erased block and the target of the rejected command, to show that only the running operation changed the array.

// File: rtl/dflash_pkg.sv
package dflash_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic captureAddr;
    logic arrRead;
    logic showData;
    logic latchCmd;
    logic progCommit;
    logic eraseCommit;
  } dfStrobes_t;

  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_WAIT,
    ACC_DATA,
    ACC_ERR
  } accState_t;

endpackage

// File: rtl/dflash_ctrl_fsm.sv
module dflash_ctrl_fsm
  import dflash_pkg::*;
#(
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuFetch,
  input  logic       cpuWrite,
  input  logic       ctrlWe,
  input  logic       ctrlWdata,
  input  logic       codeRewriting,
  input  logic       lpReq,
  input  logic       seqCmdValid,
  input  logic       seqCmdErase,
  output dfStrobes_t strobes,
  output logic       cpuDone,
  output logic       cpuErr,
  output logic       ctrlEnable,
  output logic       busy,
  output logic       seqDone,
  output logic       seqErr,
  output logic       lpGrant,
  output logic       lpDeny
);

  localparam int MAX_CYCLES = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CYCLES + 1);

  accState_t         accState, accNext;
  logic [CNT_W-1:0]  opCnt;
  logic              opErase;
  logic              enableReg;
  logic              refuse;
  logic              cmdAccept;
  logic              opFinish;

  // access refusal conditions sampled at request time
  assign refuse    = cpuFetch | cpuWrite | ~enableReg | codeRewriting | busy;
  assign cmdAccept = seqCmdValid & ~busy & enableReg & ~codeRewriting;
  assign opFinish  = busy && (opCnt == '0);

  always_comb begin
    accNext = accState;
    unique case (accState)
      ACC_IDLE: if (cpuReq) accNext = refuse ? ACC_ERR : ACC_WAIT;
      ACC_WAIT: accNext = ACC_DATA;
      ACC_DATA: accNext = ACC_IDLE;
      ACC_ERR:  accNext = ACC_IDLE;
      default:  accNext = ACC_IDLE;
    endcase
  end

  always_comb begin
    strobes             = '0;
    strobes.captureAddr = (accState == ACC_IDLE) && cpuReq && !refuse;
    strobes.arrRead     = (accState == ACC_WAIT);
    strobes.showData    = (accState == ACC_DATA);
    strobes.latchCmd    = cmdAccept;
    strobes.progCommit  = opFinish && !opErase;
    strobes.eraseCommit = opFinish && opErase;
  end

  assign cpuDone    = (accState == ACC_DATA) || (accState == ACC_ERR);
  assign cpuErr     = (accState == ACC_ERR);
  assign ctrlEnable = enableReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accState  <= ACC_IDLE;
      enableReg <= 1'b0;
      busy      <= 1'b0;
      opCnt     <= '0;
      opErase   <= 1'b0;
      seqDone   <= 1'b0;
      seqErr    <= 1'b0;
      lpGrant   <= 1'b0;
      lpDeny    <= 1'b0;
    end else begin
      accState <= accNext;
      if (ctrlWe && !busy) enableReg <= ctrlWdata;
      lpGrant <= lpReq && !busy;
      lpDeny  <= lpReq && busy;
      seqErr  <= seqCmdValid && !cmdAccept;
      seqDone <= opFinish;
      if (cmdAccept) begin
        busy    <= 1'b1;
        opErase <= seqCmdErase;
        opCnt   <= seqCmdErase ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
      end else if (opFinish) begin
        busy <= 1'b0;
      end else if (busy) begin
        opCnt <= opCnt - 1'b1;
      end
    end
  end

  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    (accState == ACC_WAIT) |=> (cpuDone && !cpuErr));

  a_r3_fetch_refused: assert property (@(posedge clk) disable iff (!rstN)
    (accState == ACC_IDLE && cpuReq && cpuFetch) |=> (cpuDone && cpuErr));

  a_r6_code_lockout: assert property (@(posedge clk) disable iff (!rstN)
    (seqCmdValid && codeRewriting && !busy) |=> (seqErr && !busy));

  a_r7_ctrl_locked: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlWe) |=> $stable(ctrlEnable));

  a_r8_lp_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(lpGrant && lpDeny));

  a_r11_busy_reject: assert property (@(posedge clk) disable iff (!rstN)
    (busy && seqCmdValid) |=> seqErr);

endmodule

// File: rtl/dflash_datapath.sv
module dflash_datapath
  import dflash_pkg::*;
#(
  parameter int DATA_BYTES  = 2048,
  parameter int BLOCK_BYTES = 1024,
  localparam int ADDR_W     = $clog2(DATA_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dfStrobes_t        strobes,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [ADDR_W-1:0] seqAddr,
  input  logic [7:0]        seqData,
  output logic [7:0]        cpuRdata
);

  localparam int OFF_W = $clog2(BLOCK_BYTES);

  logic [7:0]        mem [DATA_BYTES];
  logic [ADDR_W-1:0] rdAddr;
  logic [7:0]        rdReg;
  logic [ADDR_W-1:0] cmdAddr;
  logic [7:0]        cmdData;
  logic [7:0]        curByte;

  assign curByte  = mem[cmdAddr];
  assign cpuRdata = strobes.showData ? rdReg : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr  <= '0;
      rdReg   <= 8'h00;
      cmdAddr <= '0;
      cmdData <= 8'hFF;
    end else begin
      if (strobes.captureAddr) rdAddr <= cpuAddr;
      if (strobes.arrRead)     rdReg  <= mem[rdAddr];
      if (strobes.latchCmd) begin
        cmdAddr <= seqAddr;
        cmdData <= seqData;
      end
    end
  end

  // array: erased state is all ones; program can only clear bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < DATA_BYTES; j++) mem[j] <= 8'hFF;
    end else if (strobes.eraseCommit) begin
      for (int j = 0; j < DATA_BYTES; j++)
        if ((ADDR_W'(j) >> OFF_W) == (cmdAddr >> OFF_W)) mem[j] <= 8'hFF;
    end else if (strobes.progCommit) begin
      mem[cmdAddr] <= curByte & cmdData;
    end
  end

  a_r9_prog_only_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobes.progCommit |=> ((curByte & ~$past(curByte)) == 8'h00) && ((curByte & ~cmdData) == 8'h00));

  a_r10_erase_sets_ones: assert property (@(posedge clk) disable iff (!rstN)
    strobes.eraseCommit |=> (curByte == 8'hFF));

  a_r2_no_data_outside_slot: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.showData |-> (cpuRdata == 8'h00));

endmodule

// File: rtl/dflash_ctrl.sv
module dflash_ctrl
  import dflash_pkg::*;
#(
  parameter int DATA_BYTES   = 2048,
  parameter int BLOCK_BYTES  = 1024,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 20,
  localparam int ADDR_W      = $clog2(DATA_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuFetch,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic [7:0]        cpuRdata,
  output logic              cpuDone,
  output logic              cpuErr,
  input  logic              ctrlWe,
  input  logic              ctrlWdata,
  output logic              ctrlEnable,
  input  logic              codeRewriting,
  input  logic              lpReq,
  output logic              lpGrant,
  output logic              lpDeny,
  input  logic              seqCmdValid,
  input  logic              seqCmdErase,
  input  logic [ADDR_W-1:0] seqAddr,
  input  logic [7:0]        seqData,
  output logic              busy,
  output logic              seqDone,
  output logic              seqErr
);

  dfStrobes_t strobes;

  dflash_ctrl_fsm #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .cpuReq       (cpuReq),
    .cpuFetch     (cpuFetch),
    .cpuWrite     (cpuWrite),
    .ctrlWe       (ctrlWe),
    .ctrlWdata    (ctrlWdata),
    .codeRewriting(codeRewriting),
    .lpReq        (lpReq),
    .seqCmdValid  (seqCmdValid),
    .seqCmdErase  (seqCmdErase),
    .strobes      (strobes),
    .cpuDone      (cpuDone),
    .cpuErr       (cpuErr),
    .ctrlEnable   (ctrlEnable),
    .busy         (busy),
    .seqDone      (seqDone),
    .seqErr       (seqErr),
    .lpGrant      (lpGrant),
    .lpDeny       (lpDeny)
  );

  dflash_datapath #(
    .DATA_BYTES (DATA_BYTES),
    .BLOCK_BYTES(BLOCK_BYTES)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .cpuAddr (cpuAddr),
    .seqAddr (seqAddr),
    .seqData (seqData),
    .cpuRdata(cpuRdata)
  );

endmodule

// File: tb/tb_dflash_ctrl.sv
module tb_dflash_ctrl;

  localparam int DATA_BYTES   = 2048;
  localparam int BLOCK_BYTES  = 1024;
  localparam int PROG_CYCLES  = 6;
  localparam int ERASE_CYCLES = 20;
  localparam int ADDR_W       = $clog2(DATA_BYTES);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 0, cpuFetch = 0, cpuWrite = 0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [7:0] cpuRdata;
  logic cpuDone, cpuErr;
  logic ctrlWe = 0, ctrlWdata = 0, ctrlEnable;
  logic codeRewriting = 0, lpReq = 0, lpGrant, lpDeny;
  logic seqCmdValid = 0, seqCmdErase = 0;
  logic [ADDR_W-1:0] seqAddr = '0;
  logic [7:0] seqData = '0;
  logic busy, seqDone, seqErr;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [DATA_BYTES];

  always #2 clk = ~clk;

  dflash_ctrl #(
    .DATA_BYTES(DATA_BYTES), .BLOCK_BYTES(BLOCK_BYTES),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuFetch(cpuFetch), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuRdata(cpuRdata), .cpuDone(cpuDone), .cpuErr(cpuErr),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .ctrlEnable(ctrlEnable),
    .codeRewriting(codeRewriting), .lpReq(lpReq), .lpGrant(lpGrant), .lpDeny(lpDeny),
    .seqCmdValid(seqCmdValid), .seqCmdErase(seqCmdErase), .seqAddr(seqAddr),
    .seqData(seqData), .busy(busy), .seqDone(seqDone), .seqErr(seqErr)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int expProg(int oldV, int newV);
    return oldV & newV;
  endfunction

  // access: expErr selects the refused response
  task automatic cpuAccess(int addr, bit fetch, bit wr, bit expErr, string req);
    @(negedge clk);
    cpuReq = 1; cpuAddr = ADDR_W'(addr); cpuFetch = fetch; cpuWrite = wr;
    @(negedge clk);
    cpuReq = 0; cpuFetch = 0; cpuWrite = 0;
    if (expErr) begin
      chk({req, " err response"}, {cpuDone, cpuErr}, 2'b11);
      chk({req, " err data"}, cpuRdata, 0);
    end else begin
      chk({req, " wait cycle"}, cpuDone, 0);
      @(negedge clk);
      chk({req, " done ok"}, {cpuDone, cpuErr}, 2'b10);
      chk({req, " data"}, cpuRdata, model[addr]);
    end
  endtask

  task automatic seqIssue(bit erase, int addr, int data);
    @(negedge clk);
    seqCmdValid = 1; seqCmdErase = erase; seqAddr = ADDR_W'(addr); seqData = 8'(data);
    @(negedge clk);
    seqCmdValid = 0;
  endtask

  task automatic modelApply(bit erase, int addr, int data);
    if (erase) begin
      for (int i = 0; i < DATA_BYTES; i++)
        if ((i / BLOCK_BYTES) == (addr / BLOCK_BYTES)) model[i] = 8'hFF;
    end else begin
      model[addr] = 8'(expProg(model[addr], data));
    end
  endtask

  task automatic waitBusy(bit erase, int cntIn, string req);
    int cnt = cntIn;
    while (busy && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    chk({req, " busy length"}, cnt, erase ? ERASE_CYCLES : PROG_CYCLES);
    chk({req, " done pulse"}, seqDone, 1);
  endtask

  task automatic seqRun(bit erase, int addr, int data, string req);
    seqIssue(erase, addr, data);
    chk({req, " no reject"}, seqErr, 0);
    waitBusy(erase, 0, req);
    modelApply(erase, addr, data);
  endtask

  task automatic ctrlWrite(bit v);
    @(negedge clk); ctrlWe = 1; ctrlWdata = v;
    @(negedge clk); ctrlWe = 0;
  endtask

  task automatic lpPulse();
    @(negedge clk); lpReq = 1;
    @(negedge clk); lpReq = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < DATA_BYTES; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 enable at reset", ctrlEnable, 0);
    chk("R1 busy at reset", busy, 0);

    // disabled area
    cpuAccess(5, 0, 0, 1, "R5");
    seqIssue(0, 5, 8'h00);
    chk("R13 reject disabled", seqErr, 1);
    chk("R13 no busy", busy, 0);

    ctrlWrite(1);
    chk("R1 enable set", ctrlEnable, 1);
    cpuAccess(0, 0, 0, 0, "R1 first byte");
    cpuAccess(DATA_BYTES - 1, 0, 0, 0, "R1 last byte");
    cpuAccess(5, 0, 0, 0, "R13 byte untouched");

    // refused request kinds
    cpuAccess(7, 1, 0, 1, "R3 fetch");
    cpuAccess(7, 0, 1, 1, "R4 write");
    cpuAccess(7, 0, 0, 0, "R4 byte unchanged");

    // program AND behaviour
    seqRun(0, 100, 8'hF0, "R9 first program");
    cpuAccess(100, 0, 0, 0, "R9 read 0xF0");
    seqRun(0, 100, 8'h3C, "R9 second program");
    chk("R9 model 0x30", model[100], 8'h30);
    cpuAccess(100, 0, 0, 0, "R9 read 0x30");

    // low power when idle
    lpPulse();
    chk("R8 grant idle", {lpGrant, lpDeny}, 2'b10);

    // erase block 0, block 1 stays
    seqRun(0, BLOCK_BYTES + 3, 8'h55, "R9 program block1");
    seqRun(0, BLOCK_BYTES - 1, 8'h0F, "R9 program block0 end");
    seqRun(1, 17, 0, "R10 erase block0");
    cpuAccess(100, 0, 0, 0, "R10 erased byte");
    cpuAccess(BLOCK_BYTES - 1, 0, 0, 0, "R10 block end erased");
    cpuAccess(BLOCK_BYTES + 3, 0, 0, 0, "R10 other block kept");

    // activity during a rewrite
    seqIssue(1, BLOCK_BYTES + 9, 0);
    begin
      int used;
      used = 1;
      cpuAccess(BLOCK_BYTES + 3, 0, 0, 1, "R12 read during rewrite");
      ctrlWrite(0);
      chk("R7 enable locked", ctrlEnable, 1);
      lpPulse();
      chk("R8 deny busy", {lpGrant, lpDeny}, 2'b01);
      seqIssue(0, 200, 8'h00);
      chk("R11 reject busy", seqErr, 1);
      used = used + 7;
      waitBusy(1, used, "R10 erase block1");
    end
    modelApply(1, BLOCK_BYTES + 9, 0);
    cpuAccess(BLOCK_BYTES + 3, 0, 0, 0, "R10 block1 erased");
    cpuAccess(200, 0, 0, 0, "R11 rejected target kept");
    chk("R11 model 200", model[200], 8'hFF);

    // code area rewrite lockout
    codeRewriting = 1;
    cpuAccess(3, 0, 0, 1, "R6 read refused");
    seqIssue(0, 3, 8'h00);
    chk("R6 command rejected", seqErr, 1);
    chk("R6 no busy", busy, 0);
    codeRewriting = 0;
    cpuAccess(3, 0, 0, 0, "R6 byte kept");

    // random traffic
    for (int it = 0; it < 300; it++) begin
      int op, a;
      op = int'($urandom % 10);
      a  = int'($urandom % DATA_BYTES);
      if (op < 5) cpuAccess(a, 0, 0, 0, "R2 random read");
      else if (op < 8) seqRun(0, a, int'($urandom % 256), "R9 random program");
      else if (op == 8) cpuAccess(a, 1, 0, 1, "R3 random fetch");
      else if (($urandom % 3) == 0) seqRun(1, a, 0, "R10 random erase");
      else cpuAccess(a, 0, 1, 1, "R4 random write");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule